// File: doc/BRIEF.md
# Debug Session Controller

This block sequences a debug session between a command port, which a JTAG front end drives, and a processor core. A core-resource access or a hardware debug request raises a halt request to the core. The block enters the debug state only after the core acknowledges that it has finished its current instruction and stopped. The session and the debug state are tracked separately. A go-without-exit command runs one instruction and then returns to debug, and the session stays open while it does. A go-with-exit command closes the session and hands the core back the power mode it was in before the session opened. If a new hardware request is pending at that moment, the core stays in debug instead.

Each go command needs a fresh scan of the core scan-chain register. The scan is reported to this block by a one-cycle strobe, and one accepted go consumes it. Commands arrive on a valid/ready port. The port accepts a command in a cycle where both `cmd_valid` and `cmd_ready` are high. `cmd_ready` is high only while the controller is idle or in the debug state, so the sender must hold `cmd_valid` and `cmd_op` stable while `cmd_ready` is low. The core handshake, the scan strobe and the status lines are plain control pins.

Top module: `dbg_session_ctrl`

## Requirements
- R1: An accepted op 0 (internal-register access) never raises `core_dbg_req`, and the controller stays idle with `session_active` low.
- R2: In idle, an accepted op 1 (core-resource access) or a high `hw_dbg_req` raises `core_dbg_req` on the next cycle. It stays high until a cycle with `core_dbg_ack`, and `cmd_ready` is low for that whole time.
- R3: While the request is raised, `core_wake` is high exactly when the power mode captured at request time is not RUN. The mode encoding is 0 RUN, 1 WAIT, 2 STOP, 3 HALT.
- R4: The cycle after `core_dbg_ack` is seen during a request, `stat_in_debug` and `session_active` are high and `core_dbg_req` is low.
- R5: In debug, an accepted op 2 (go without exit) with a fresh scan drives `core_step` high and `stat_in_debug` low from the next cycle, with `session_active` still high. The cycle after `core_step_done`, the controller is back in debug.
- R6: In debug, an accepted op 3 (go with exit) with a fresh scan and `hw_dbg_req` low gives one cycle with `restore_valid` high and `restore_mode` equal to the captured mode. The cycle after that the controller is idle.
- R7: An op 3 with a fresh scan while `hw_dbg_req` is high keeps the controller in debug with no restore pulse, and it consumes the scan.
- R8: A go (op 2 or 3) in debug without a scan strobe since the last accepted go is ignored, and it sets `stat_go_err` on the next cycle. A `scan_done` strobe clears `stat_go_err` on the next cycle.
- R9: `session_active` is high in the debug, step and exit cycles, and it falls only after the restore cycle.
- R10: With `rst_n` low at a clock edge, the controller goes idle. `session_active`, `core_dbg_req`, `core_wake`, `core_step`, `restore_valid` and `stat_go_err` are all low after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Controller can accept a command |
| cmd_op | input | 2 | 0 internal access, 1 core access, 2 go without exit, 3 go with exit |
| scan_done | input | 1 | One-cycle strobe: core scan-chain register was scanned |
| hw_dbg_req | input | 1 | Pending hardware debug request |
| core_mode | input | MODE_W | Current core power mode |
| core_dbg_req | output | 1 | Halt request to the core |
| core_wake | output | 1 | Force the core out of its low-power state |
| core_dbg_ack | input | 1 | Core has stopped in debug |
| core_step | output | 1 | Core executes one instruction |
| core_step_done | input | 1 | Single instruction retired |
| restore_valid | output | 1 | One-cycle strobe: return the core to the saved mode |
| restore_mode | output | MODE_W | Mode to return to |
| session_active | output | 1 | Debug session in progress |
| stat_in_debug | output | 1 | Core is in the debug state |
| stat_go_err | output | 1 | Sticky flag: a go was rejected for a missing scan |

## Verification
Every output is decoded from a register that the input sampled at one edge updates, so each result is due exactly one cycle after its stimulus. This covers the request after a command, debug entry after the acknowledge, the step and back, the restore strobe, and setting or clearing the go error. Idle follows the restore strobe one cycle later again. The bench drives inputs, waits for one rising edge, and samples a moment after it, before the next edge. It runs the full session sequence once for each of the four captured power modes, and it also checks the paths through the hardware request and through reset.

// File: rtl/dbg_sess_pkg.sv
package dbg_sess_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_REQ   = 3'd1,
    ST_DEBUG = 3'd2,
    ST_STEP  = 3'd3,
    ST_EXIT  = 3'd4
  } sess_state_e;

  typedef enum logic [1:0] {
    OP_LOCAL   = 2'd0,
    OP_CORE    = 2'd1,
    OP_GO_STAY = 2'd2,
    OP_GO_EXIT = 2'd3
  } sess_op_e;
endpackage

// File: rtl/dbg_scan_gate.sv
module dbg_scan_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic scan_done,
  input  logic go_take,
  input  logic go_reject,
  output logic scan_fresh,
  output logic go_err
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scan_fresh <= 1'b0;
      go_err     <= 1'b0;
    end else begin
      if (scan_done)    scan_fresh <= 1'b1;
      else if (go_take) scan_fresh <= 1'b0;
      if (scan_done)      go_err <= 1'b0;
      else if (go_reject) go_err <= 1'b1;
    end
  end

  // R8: scan strobe always clears the sticky error
  p_err_cleared_r8: assert property (@(posedge clk) disable iff (!rst_n)
    scan_done |=> !go_err);
  // R8: rejected go without scan leaves the error set
  p_err_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (go_reject && !scan_done) |=> go_err);
endmodule

// File: rtl/dbg_mode_hold.sv
module dbg_mode_hold #(
  parameter int MODE_W   = 2,
  parameter int RUN_MODE = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic [MODE_W-1:0] mode_in,
  output logic [MODE_W-1:0] saved_mode,
  output logic              was_asleep
);
  localparam logic [MODE_W-1:0] RunCode = MODE_W'(RUN_MODE);

  always_ff @(posedge clk) begin
    if (!rst_n)       saved_mode <= RunCode;
    else if (capture) saved_mode <= mode_in;
  end

  assign was_asleep = (saved_mode != RunCode);
endmodule

// File: rtl/dbg_sess_fsm.sv
module dbg_sess_fsm
  import dbg_sess_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_fire,
  input  logic [1:0]  cmd_op,
  input  logic        hw_dbg_req,
  input  logic        core_dbg_ack,
  input  logic        core_step_done,
  input  logic        scan_fresh,
  output sess_state_e state,
  output logic        capture,
  output logic        go_take,
  output logic        go_reject
);
  sess_state_e nxt;
  logic is_go;

  assign is_go     = cmd_fire && (cmd_op == OP_GO_STAY || cmd_op == OP_GO_EXIT);
  assign go_take   = (state == ST_DEBUG) && is_go && scan_fresh;
  assign go_reject = (state == ST_DEBUG) && is_go && !scan_fresh;
  assign capture   = (state == ST_IDLE) &&
                     (hw_dbg_req || (cmd_fire && cmd_op == OP_CORE));

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE:  if (capture) nxt = ST_REQ;
      ST_REQ:   if (core_dbg_ack) nxt = ST_DEBUG;
      ST_DEBUG: begin
        if (go_take && cmd_op == OP_GO_STAY) nxt = ST_STEP;
        else if (go_take && !hw_dbg_req)     nxt = ST_EXIT;
      end
      ST_STEP:  if (core_step_done) nxt = ST_DEBUG;
      ST_EXIT:  nxt = ST_IDLE;
      default:  nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nxt;
  end

  // R2: request waits for acknowledge
  p_req_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_REQ && !core_dbg_ack) |=> state == ST_REQ);
  // R4: acknowledge enters debug
  p_ack_enters_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_REQ && core_dbg_ack) |=> state == ST_DEBUG);
  // R5: step completes back into debug
  p_step_return_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_STEP && core_step_done) |=> state == ST_DEBUG);
  // R8: rejected go does not move the controller
  p_reject_stays_r8: assert property (@(posedge clk) disable iff (!rst_n)
    go_reject |=> state == ST_DEBUG);
  // R6: exit lasts one cycle
  p_exit_once_r6: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_EXIT |=> state == ST_IDLE);
endmodule

// File: rtl/dbg_session_ctrl.sv
module dbg_session_ctrl
  import dbg_sess_pkg::*;
#(
  parameter int MODE_W   = 2,
  parameter int RUN_MODE = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [1:0]        cmd_op,
  input  logic              scan_done,
  input  logic              hw_dbg_req,
  input  logic [MODE_W-1:0] core_mode,
  output logic              core_dbg_req,
  output logic              core_wake,
  input  logic              core_dbg_ack,
  output logic              core_step,
  input  logic              core_step_done,
  output logic              restore_valid,
  output logic [MODE_W-1:0] restore_mode,
  output logic              session_active,
  output logic              stat_in_debug,
  output logic              stat_go_err
);
  sess_state_e state;
  logic cmd_fire, capture, go_take, go_reject, scan_fresh, was_asleep;

  assign cmd_ready = (state == ST_IDLE) || (state == ST_DEBUG);
  assign cmd_fire  = cmd_valid && cmd_ready;

  dbg_sess_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .cmd_fire(cmd_fire), .cmd_op(cmd_op),
    .hw_dbg_req(hw_dbg_req), .core_dbg_ack(core_dbg_ack),
    .core_step_done(core_step_done), .scan_fresh(scan_fresh),
    .state(state), .capture(capture), .go_take(go_take), .go_reject(go_reject)
  );

  dbg_scan_gate u_scan (
    .clk(clk), .rst_n(rst_n), .scan_done(scan_done), .go_take(go_take),
    .go_reject(go_reject), .scan_fresh(scan_fresh), .go_err(stat_go_err)
  );

  dbg_mode_hold #(.MODE_W(MODE_W), .RUN_MODE(RUN_MODE)) u_mode (
    .clk(clk), .rst_n(rst_n), .capture(capture), .mode_in(core_mode),
    .saved_mode(restore_mode), .was_asleep(was_asleep)
  );

  assign core_dbg_req   = (state == ST_REQ);
  assign core_wake      = (state == ST_REQ) && was_asleep;
  assign core_step      = (state == ST_STEP);
  assign restore_valid  = (state == ST_EXIT);
  assign stat_in_debug  = (state == ST_DEBUG);
  assign session_active = (state == ST_DEBUG) || (state == ST_STEP) ||
                          (state == ST_EXIT);

  // R9: session stays up across a step
  p_step_in_session_r9: assert property (@(posedge clk) disable iff (!rst_n)
    core_step |-> session_active);
  // R9: session drops after the restore strobe
  p_drop_after_restore_r9: assert property (@(posedge clk) disable iff (!rst_n)
    restore_valid |=> !session_active);
  // R2: no commands taken while the request is outstanding
  p_busy_in_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    core_dbg_req |-> !cmd_ready);
  // R3: wake only accompanies a request
  p_wake_with_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
    core_wake |-> core_dbg_req);
endmodule

// File: tb/sim_dbg_session_ctrl.sv
module sim_dbg_session_ctrl;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0, scan_done = 1'b0, hw_dbg_req = 1'b0;
  logic core_dbg_ack = 1'b0, core_step_done = 1'b0;
  logic [1:0] cmd_op = 2'd0, core_mode = 2'd0;
  logic cmd_ready, core_dbg_req, core_wake, core_step, restore_valid;
  logic [1:0] restore_mode;
  logic session_active, stat_in_debug, stat_go_err;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dbg_session_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .scan_done(scan_done), .hw_dbg_req(hw_dbg_req),
    .core_mode(core_mode), .core_dbg_req(core_dbg_req), .core_wake(core_wake),
    .core_dbg_ack(core_dbg_ack), .core_step(core_step),
    .core_step_done(core_step_done), .restore_valid(restore_valid),
    .restore_mode(restore_mode), .session_active(session_active),
    .stat_in_debug(stat_in_debug), .stat_go_err(stat_go_err)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
    cmd_valid = 0; scan_done = 0; core_dbg_ack = 0; core_step_done = 0;
  endtask

  task automatic cmd(input logic [1:0] op);
    cmd_valid = 1; cmd_op = op;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    tick(); tick();
    rst_n = 1;
    // R10 reset state
    chk("R10 session", session_active, 0);
    chk("R10 req", core_dbg_req, 0);
    chk("R10 ready", cmd_ready, 1);
    for (int m = 0; m < 4; m++) begin
      core_mode = 2'(m);
      cmd(2'd0); tick();                        // R1 internal access
      chk("R1 no req", core_dbg_req, 0);
      chk("R1 session", session_active, 0);
      cmd(2'd1); tick();                        // R2 core access
      chk("R2 req", core_dbg_req, 1);
      chk("R2 ready low", cmd_ready, 0);
      chk("R3 wake", core_wake, (m != 0) ? 1 : 0);
      core_mode = 2'd0; tick();                 // request held, mode captured
      chk("R2 req held", core_dbg_req, 1);
      chk("R3 wake held", core_wake, (m != 0) ? 1 : 0);
      core_dbg_ack = 1; tick();
      chk("R4 in debug", stat_in_debug, 1);
      chk("R4 session", session_active, 1);
      chk("R4 req low", core_dbg_req, 0);
      cmd(2'd2); tick();                        // R8 no scan yet
      chk("R8 err set", stat_go_err, 1);
      chk("R8 no step", core_step, 0);
      chk("R8 in debug", stat_in_debug, 1);
      scan_done = 1; tick();
      chk("R8 err clear", stat_go_err, 0);
      cmd(2'd2); tick();                        // R5 step
      chk("R5 step", core_step, 1);
      chk("R5 not debug", stat_in_debug, 0);
      chk("R9 session in step", session_active, 1);
      tick();
      chk("R5 step waits", core_step, 1);
      core_step_done = 1; tick();
      chk("R5 back", stat_in_debug, 1);
      chk("R5 step low", core_step, 0);
      cmd(2'd3); tick();                        // R8 scan consumed
      chk("R8 exit rejected", stat_go_err, 1);
      chk("R8 no restore", restore_valid, 0);
      scan_done = 1; tick();
      hw_dbg_req = 1; cmd(2'd3); tick();        // R7 pending request
      hw_dbg_req = 0;
      chk("R7 stays debug", stat_in_debug, 1);
      chk("R7 no restore", restore_valid, 0);
      cmd(2'd3); tick();                        // R7 scan consumed
      chk("R7 consumed", stat_go_err, 1);
      scan_done = 1; tick();
      cmd(2'd3); tick();                        // R6 exit
      chk("R6 restore", restore_valid, 1);
      chk("R6 mode", restore_mode, m);
      chk("R9 session in exit", session_active, 1);
      tick();
      chk("R9 session drop", session_active, 0);
      chk("R6 restore low", restore_valid, 0);
      chk("R6 idle ready", cmd_ready, 1);
    end
    // R2 via hardware request, then R10 mid-session
    core_mode = 2'd3; hw_dbg_req = 1; tick(); hw_dbg_req = 0;
    chk("R2 hw req", core_dbg_req, 1);
    chk("R3 hw wake", core_wake, 1);
    core_dbg_ack = 1; tick();
    chk("R4 hw debug", session_active, 1);
    scan_done = 1; tick();
    cmd(2'd2); tick();
    chk("R5 hw step", core_step, 1);
    rst_n = 0; tick(); rst_n = 1;
    chk("R10 step cleared", core_step, 0);
    chk("R10 session cleared", session_active, 0);
    chk("R10 err", stat_go_err, 0);
    cmd(2'd2); tick();                          // go in idle is ignored
    chk("R10 idle after", core_step, 0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule